// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs program and erase operations on an embedded flash array on behalf of a CPU. Its inputs are the CPU's array port and a set of command levels that a separate register block holds. A CPU write to the array does not reach the array directly. It starts the operation that the command levels select: a single word or byte program, a sequential block program, an erase of one segment, or an erase of the whole array. A phase counter, advanced by a strobe from the divided flash clock, times each operation. When the phase ends, the block sends one pulse to the array.

While an operation runs, the block raises a busy output. In block mode it also drives a wait output that tells software when the next word may be written. Any CPU access during an operation is refused and reported on a one-cycle violation strobe. An abort input ends any operation at once. When a block ends, a short fixed recovery phase runs before busy falls.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy, waitFlag, accessViol, eraseClr and the three array strobes (arrProg, arrErSeg, arrErAll) are all 0.
- R2: While lockIn is 1, a CPU write starts no operation and leaves the array unchanged. CPU reads still return array contents.
- R3: With cmdWrite=1 and cmdBlock=0, a CPU write programs its data into the array. A word write uses an even address. A byte write (cpuByte=1) changes only the addressed byte, taken from cpuWdata[7:0]. Programming can only clear bits.
- R4: A dummy write with cmdErase=1 sets every byte of the SEG_BYTES-aligned segment that holds the address to 0xFF and leaves the other segments untouched. Erase bits take priority over cmdWrite. eraseClr pulses for one cycle as the erase completes.
- R5: A dummy write with cmdMass=1 sets every byte of the array to 0xFF.
- R6: busy rises on the clock edge that accepts the start write and falls automatically after the phase count. With flashTick held at 1, a word program keeps busy high for PROG_TICKS+1 cycles. With a slower tick, the busy time scales with the tick period.
- R7: In block mode (cmdWrite=1, cmdBlock=1), waitFlag is 0 while a word is being programmed. It rises to 1 when the next word may be written. busy stays 1 between the words of a block.
- R8: In block mode, a write is accepted only at the word address that follows the previous one. After the word at block offset 0x3E of a 64-byte aligned block, no further write is accepted. A refused write does not change the array.
- R9: When cmdBlock falls while the block sequencer is waiting, busy stays 1 and waitFlag is 0 for REC_TICKS+1 cycles, and then busy returns to 0.
- R10: A CPU read during busy returns 16'h3FFF instead of array data. Any CPU access that is not an accepted block word pulses accessViol in the cycle it is presented.
- R11: When abortReq is 1 during an operation, busy is 0 from the next cycle. No array strobe or eraseClr is issued, and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flashTick | input | 1 | One strobe per divided flash clock period |
| cpuReq | input | 1 | CPU array access request |
| cpuWe | input | 1 | 1 for write, 0 for read |
| cpuByte | input | 1 | Byte-wide write |
| cpuAddr | input | ADDR_W | CPU byte address |
| cpuWdata | input | 16 | CPU write data |
| cpuRdata | output | 16 | Read data to CPU |
| cmdWrite | input | 1 | Program command level |
| cmdBlock | input | 1 | Block program command level |
| cmdErase | input | 1 | Segment erase command level |
| cmdMass | input | 1 | Whole-array erase command level |
| lockIn | input | 1 | Lock against program and erase |
| abortReq | input | 1 | Emergency stop |
| busy | output | 1 | Operation in progress |
| waitFlag | output | 1 | Block mode ready for next word |
| accessViol | output | 1 | Refused-access strobe |
| eraseClr | output | 1 | Erase finished, clear the erase command |
| arrAddr | output | ADDR_W | Array address |
| arrWdata | output | 16 | Array program data |
| arrByte | output | 1 | Array program is byte-wide |
| arrProg | output | 1 | Array program strobe |
| arrErSeg | output | 1 | Array segment erase strobe |
| arrErAll | output | 1 | Array full erase strobe |
| arrRdata | input | 16 | Array read data |

## Verification
A wrong sequencer state shows up at the ports in one of three ways: busy stays high too long or falls too early, waitFlag is wrong, or an array strobe arrives at the wrong time. A busy-cycle count taken right after each start exposes a wrong phase length or a lost tick within one operation. A wrong sequential-address latch or block-end flag shows up at once, either as a refused write that should have been accepted or as data that read-back finds in the wrong place. A stuck abort or lock path leaves a read-back that differs from the value the bench predicts.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_ONE,
    ST_PROG_BLK,
    ST_BLK_WAIT,
    ST_RECOVER,
    ST_ER_SEG,
    ST_ER_ALL
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PROG,
    PH_SEG,
    PH_MASS,
    PH_REC
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   loadCnt;
    phase_e phase;
    logic   wordOnly;
  } seq_ctl_t;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int PROG_TICKS  = 35,
  parameter int SEG_TICKS   = 4000,
  parameter int MASS_TICKS  = 5000,
  parameter int REC_TICKS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flashTick,
  input  seq_ctl_t          ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [15:0]       cpuWdata,
  input  logic              cpuByte,
  output logic              cntZero,
  output logic              seqOk,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [15:0]       latchData,
  output logic              latchByte
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_TICKS = maxOf(maxOf(PROG_TICKS, SEG_TICKS), maxOf(MASS_TICKS, REC_TICKS));
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int BLK_OFF_W = $clog2(BLOCK_BYTES);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  phaseLen;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] wordAddr;
  logic              blockEnd;

  assign wordAddr = {cpuAddr[ADDR_W-1:1], 1'b0};

  always_comb begin
    case (ctl.phase)
      PH_PROG: phaseLen = CNT_W'(PROG_TICKS);
      PH_SEG:  phaseLen = CNT_W'(SEG_TICKS);
      PH_MASS: phaseLen = CNT_W'(MASS_TICKS);
      default: phaseLen = CNT_W'(REC_TICKS);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadCnt) begin
      cnt <= phaseLen;
    end else if (flashTick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchAddr <= '0;
      latchData <= '0;
      latchByte <= 1'b0;
      nextAddr  <= '0;
      blockEnd  <= 1'b0;
    end else if (ctl.capture) begin
      latchAddr <= ctl.wordOnly ? wordAddr : cpuAddr;
      latchData <= cpuWdata;
      latchByte <= cpuByte & ~ctl.wordOnly;
      nextAddr  <= wordAddr + ADDR_W'(2);
      blockEnd  <= &cpuAddr[BLK_OFF_W-1:1];
    end
  end

  assign seqOk = ~blockEnd && (cpuAddr == nextAddr);

  // a loaded phase is never empty
  assert_cnt_loaded_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCnt |=> !cntZero);

endmodule

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl
  import flash_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     cpuWe,
  input  logic     cmdWrite,
  input  logic     cmdBlock,
  input  logic     cmdErase,
  input  logic     cmdMass,
  input  logic     lockIn,
  input  logic     abortReq,
  input  logic     cntZero,
  input  logic     seqOk,
  output seq_ctl_t ctl,
  output logic     busy,
  output logic     waitFlag,
  output logic     accessViol,
  output logic     arrProg,
  output logic     arrErSeg,
  output logic     arrErAll,
  output logic     eraseClr
);

  seq_state_e state, stateNext;
  logic startWr;
  logic blkAccept;

  assign busy     = (state != ST_IDLE);
  assign waitFlag = (state == ST_BLK_WAIT);
  assign startWr  = cpuReq && cpuWe && !lockIn && !abortReq;
  assign blkAccept = (state == ST_BLK_WAIT) && cpuReq && cpuWe && cmdWrite &&
                     cmdBlock && seqOk && !abortReq;
  assign accessViol = busy && cpuReq && !blkAccept;

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    ctl.phase    = PH_PROG;
    arrProg      = 1'b0;
    arrErSeg     = 1'b0;
    arrErAll     = 1'b0;
    eraseClr     = 1'b0;
    if (abortReq) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startWr) begin
            if (cmdMass) begin
              stateNext   = ST_ER_ALL;
              ctl.phase   = PH_MASS;
              ctl.loadCnt = 1'b1;
              ctl.capture = 1'b1;
            end else if (cmdErase) begin
              stateNext   = ST_ER_SEG;
              ctl.phase   = PH_SEG;
              ctl.loadCnt = 1'b1;
              ctl.capture = 1'b1;
            end else if (cmdWrite) begin
              stateNext    = cmdBlock ? ST_PROG_BLK : ST_PROG_ONE;
              ctl.phase    = PH_PROG;
              ctl.loadCnt  = 1'b1;
              ctl.capture  = 1'b1;
              ctl.wordOnly = cmdBlock;
            end
          end
        end
        ST_PROG_ONE: begin
          if (cntZero) begin
            arrProg   = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        ST_PROG_BLK: begin
          if (cntZero) begin
            arrProg   = 1'b1;
            stateNext = ST_BLK_WAIT;
          end
        end
        ST_BLK_WAIT: begin
          if (!cmdBlock) begin
            stateNext   = ST_RECOVER;
            ctl.phase   = PH_REC;
            ctl.loadCnt = 1'b1;
          end else if (blkAccept) begin
            stateNext    = ST_PROG_BLK;
            ctl.phase    = PH_PROG;
            ctl.loadCnt  = 1'b1;
            ctl.capture  = 1'b1;
            ctl.wordOnly = 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cntZero) stateNext = ST_IDLE;
        end
        ST_ER_SEG: begin
          if (cntZero) begin
            arrErSeg  = 1'b1;
            eraseClr  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        ST_ER_ALL: begin
          if (cntZero) begin
            arrErAll  = 1'b1;
            eraseClr  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_wait_in_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    waitFlag |-> busy);

  assert_no_start_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!lockIn));

  assert_abort_stops_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abortReq) |=> !busy);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrProg, arrErSeg, arrErAll}));

  assert_erase_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    eraseClr |=> !busy);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          BLOCK_BYTES  = 64,
  parameter int          PROG_TICKS   = 35,
  parameter int          SEG_TICKS    = 4000,
  parameter int          MASS_TICKS   = 5000,
  parameter int          REC_TICKS    = 6,
  parameter logic [15:0] BLOCKED_DATA = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flashTick,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuByte,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [15:0]       cpuWdata,
  output logic [15:0]       cpuRdata,
  input  logic              cmdWrite,
  input  logic              cmdBlock,
  input  logic              cmdErase,
  input  logic              cmdMass,
  input  logic              lockIn,
  input  logic              abortReq,
  output logic              busy,
  output logic              waitFlag,
  output logic              accessViol,
  output logic              eraseClr,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [15:0]       arrWdata,
  output logic              arrByte,
  output logic              arrProg,
  output logic              arrErSeg,
  output logic              arrErAll,
  input  logic [15:0]       arrRdata
);

  seq_ctl_t          ctl;
  logic              cntZero;
  logic              seqOk;
  logic [ADDR_W-1:0] latchAddr;

  flash_seq_ctl ctl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cmdWrite(cmdWrite), .cmdBlock(cmdBlock), .cmdErase(cmdErase), .cmdMass(cmdMass),
    .lockIn(lockIn), .abortReq(abortReq), .cntZero(cntZero), .seqOk(seqOk),
    .ctl(ctl), .busy(busy), .waitFlag(waitFlag), .accessViol(accessViol),
    .arrProg(arrProg), .arrErSeg(arrErSeg), .arrErAll(arrErAll), .eraseClr(eraseClr)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .PROG_TICKS(PROG_TICKS),
    .SEG_TICKS(SEG_TICKS), .MASS_TICKS(MASS_TICKS), .REC_TICKS(REC_TICKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .flashTick(flashTick), .ctl(ctl),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuByte(cpuByte),
    .cntZero(cntZero), .seqOk(seqOk), .latchAddr(latchAddr),
    .latchData(arrWdata), .latchByte(arrByte)
  );

  assign arrAddr  = busy ? latchAddr : cpuAddr;
  assign cpuRdata = busy ? BLOCKED_DATA : arrRdata;

  assert_read_flagged_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpuReq && !cpuWe) |-> accessViol);

endmodule

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;

  localparam int AW    = 11;
  localparam int NB    = 1 << AW;
  localparam int SEG   = 512;
  localparam int PROGT = 35;
  localparam int SEGT  = 4000;
  localparam int MASST = 5000;
  localparam int RECT  = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flashTick = 1'b1;
  logic          cpuReq = 1'b0, cpuWe = 1'b0, cpuByte = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [15:0]   cpuWdata = '0;
  logic [15:0]   cpuRdata;
  logic          cmdWrite = 1'b0, cmdBlock = 1'b0, cmdErase = 1'b0, cmdMass = 1'b0;
  logic          lockIn = 1'b0, abortReq = 1'b0;
  logic          busy, waitFlag, accessViol, eraseClr;
  logic [AW-1:0] arrAddr;
  logic [15:0]   arrWdata, arrRdata;
  logic          arrByte, arrProg, arrErSeg, arrErAll;

  logic [7:0] mem [NB];
  int nChecks = 0;
  int nFails  = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  bit done    = 0;
  bit sawClr  = 0;

  always #2 clk = ~clk;

  flash_seq #(.ADDR_W(AW), .PROG_TICKS(PROGT), .SEG_TICKS(SEGT),
              .MASS_TICKS(MASST), .REC_TICKS(RECT)) dut_i (
    .clk(clk), .rstN(rstN), .flashTick(flashTick), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuByte(cpuByte), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cmdWrite(cmdWrite), .cmdBlock(cmdBlock), .cmdErase(cmdErase), .cmdMass(cmdMass),
    .lockIn(lockIn), .abortReq(abortReq), .busy(busy), .waitFlag(waitFlag),
    .accessViol(accessViol), .eraseClr(eraseClr), .arrAddr(arrAddr), .arrWdata(arrWdata),
    .arrByte(arrByte), .arrProg(arrProg), .arrErSeg(arrErSeg), .arrErAll(arrErAll),
    .arrRdata(arrRdata)
  );

  // array model
  assign arrRdata = {mem[{arrAddr[AW-1:1], 1'b1}], mem[{arrAddr[AW-1:1], 1'b0}]};

  always @(posedge clk) begin
    if (arrProg) begin
      if (arrByte) mem[arrAddr] <= mem[arrAddr] & arrWdata[7:0];
      else begin
        mem[{arrAddr[AW-1:1], 1'b0}] <= mem[{arrAddr[AW-1:1], 1'b0}] & arrWdata[7:0];
        mem[{arrAddr[AW-1:1], 1'b1}] <= mem[{arrAddr[AW-1:1], 1'b1}] & arrWdata[15:8];
      end
    end
    if (arrErSeg)
      for (int i = 0; i < SEG; i++) mem[(int'(arrAddr) / SEG) * SEG + i] <= 8'hFF;
    if (arrErAll)
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    if (eraseClr) sawClr <= 1'b1;
  end

  always @(negedge clk) begin
    tickCnt = (tickCnt + 1 >= tickDiv) ? 0 : tickCnt + 1;
    flashTick = (tickCnt == 0);
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int got, input int lo, input int hi);
    nChecks++;
    if (got < lo || got > hi) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  // presents a write for one cycle; returns accessViol seen during it
  task automatic cpuWrite(input logic [AW-1:0] a, input logic [15:0] d, input logic b,
                          output logic viol);
    cpuReq = 1; cpuWe = 1; cpuAddr = a; cpuWdata = d; cpuByte = b;
    #1 viol = accessViol;
    @(negedge clk);
    cpuReq = 0; cpuWe = 0; cpuByte = 0;
  endtask

  task automatic cpuRead(input logic [AW-1:0] a, output logic [15:0] d, output logic viol);
    cpuReq = 1; cpuWe = 0; cpuAddr = a;
    #1 d = cpuRdata; viol = accessViol;
    @(negedge clk);
    cpuReq = 0;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic waitReady();
    int n = 0;
    while (!waitFlag && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 wait", waitFlag, 0);
    check("R1 viol/clr", {accessViol, eraseClr}, 0);
    check("R1 strobes", {arrProg, arrErSeg, arrErAll}, 0);
  endtask

  task automatic t_lock();
    logic v; logic [15:0] d;
    lockIn = 1; cmdWrite = 1;
    cpuWrite(11'h010, 16'h1234, 0, v);
    check("R2 no busy when locked", busy, 0);
    repeat (PROGT + 4) @(negedge clk);
    cpuRead(11'h010, d, v);
    check("R2 locked read data", d, 16'hFFFF);
    lockIn = 0; cmdWrite = 0;
  endtask

  task automatic t_word();
    logic v; logic [15:0] d; int n;
    cmdWrite = 1;
    cpuWrite(11'h020, 16'hA55A, 0, v);
    busyLen(n);
    check("R6 word busy cycles", n, PROGT + 1);
    cpuRead(11'h020, d, v);
    check("R3 word data", d, 16'hA55A);
    cpuWrite(11'h031, 16'h0012, 1, v);
    busyLen(n);
    cpuRead(11'h030, d, v);
    check("R3 byte write high", d, 16'h12FF);
    tickDiv = 3;
    cpuWrite(11'h040, 16'h0F0F, 0, v);
    busyLen(n);
    checkRange("R6 divided tick busy", n, 3 * PROGT - 3, 3 * PROGT + 4);
    tickDiv = 1;
    cpuRead(11'h040, d, v);
    check("R3 word data slow tick", d, 16'h0F0F);
    cmdWrite = 0;
  endtask

  task automatic t_viol();
    logic v; logic [15:0] d; int n;
    cmdWrite = 1;
    cpuWrite(11'h050, 16'h5005, 0, v);
    cpuRead(11'h020, d, v);
    check("R10 blocked read data", d, 16'h3FFF);
    check("R10 read viol", v, 1);
    cpuWrite(11'h060, 16'h0000, 0, v);
    check("R10 write viol", v, 1);
    busyLen(n);
    cpuRead(11'h050, d, v);
    check("R10 op data intact", d, 16'h5005);
    check("R10 no viol idle", v, 0);
    cpuRead(11'h060, d, v);
    check("R10 refused write no effect", d, 16'hFFFF);
    cmdWrite = 0;
  endtask

  task automatic t_seg();
    logic v; logic [15:0] d; int n;
    cmdWrite = 1;
    cpuWrite(11'h300, 16'h0000, 0, v);
    busyLen(n);
    cmdErase = 1;
    sawClr = 0;
    cpuWrite(11'h210, 16'h0000, 0, v);
    busyLen(n);
    check("R4 seg erase busy", n, SEGT + 1);
    check("R4 eraseClr pulsed", sawClr, 1);
    cpuRead(11'h300, d, v);
    check("R4 segment erased", d, 16'hFFFF);
    cpuRead(11'h210, d, v);
    check("R4 no program with erase", d, 16'hFFFF);
    cpuRead(11'h020, d, v);
    check("R4 other segment kept", d, 16'hA55A);
    cmdErase = 0; cmdWrite = 0;
  endtask

  task automatic t_abort();
    logic v; logic [15:0] d;
    cmdErase = 1; sawClr = 0;
    cpuWrite(11'h020, 16'h0000, 0, v);
    repeat (10) @(negedge clk);
    abortReq = 1;
    @(negedge clk);
    check("R11 busy after abort", busy, 0);
    abortReq = 0; cmdErase = 0;
    repeat (SEGT / 2) @(negedge clk);
    check("R11 no eraseClr", sawClr, 0);
    cpuRead(11'h020, d, v);
    check("R11 data kept", d, 16'hA55A);
  endtask

  task automatic t_block();
    logic v; logic [15:0] d; int n;
    cmdWrite = 1; cmdBlock = 1;
    cpuWrite(11'h0C0, 16'hB0C0, 0, v);
    check("R7 wait low while programming", {busy, waitFlag}, 2'b10);
    waitReady();
    check("R7 wait high, busy kept", {busy, waitFlag}, 2'b11);
    cpuWrite(11'h0C6, 16'h0000, 0, v);
    check("R8 out of order refused", v, 1);
    check("R8 still waiting", waitFlag, 1);
    for (int a = 'h0C2; a <= 'h0FE; a += 2) begin
      cpuWrite(11'(a), 16'hB000 | 16'(a), 0, v);
      if (a == 'h0C2) check("R8 sequential accepted", v, 0);
      waitReady();
    end
    cpuWrite(11'h100, 16'h0000, 0, v);
    check("R8 past block end refused", v, 1);
    cmdBlock = 0;
    @(negedge clk);
    check("R9 recovery wait low", {busy, waitFlag}, 2'b10);
    busyLen(n);
    check("R9 recovery length", n, RECT + 1);
    cmdWrite = 0;
    cpuRead(11'h0C6, d, v);
    check("R8 refused data absent", d, 16'hB0C6);
    cpuRead(11'h0FE, d, v);
    check("R7 last word", d, 16'hB0FE);
    cpuRead(11'h100, d, v);
    check("R8 beyond block untouched", d, 16'hFFFF);
  endtask

  task automatic t_mass();
    logic v; logic [15:0] d; int n;
    cmdMass = 1;
    cpuWrite(11'h7FE, 16'h0000, 0, v);
    busyLen(n);
    check("R5 mass busy", n, MASST + 1);
    cpuRead(11'h0C6, d, v);
    check("R5 erased block", d, 16'hFFFF);
    cpuRead(11'h030, d, v);
    check("R5 erased byte word", d, 16'hFFFF);
    cmdMass = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_word();
    t_viol();
    t_seg();
    t_abort();
    t_block();
    t_mass();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule